// File: doc/BRIEF.md
# Per-Read Skew-Training Capture Aligner

This block sits on the host side of a double-rate, common-clock flash read path that returns no data strobe. The data lines reach it already split into several delayed copies, one copy per candidate delay tap, and already brought to one beat per clock cycle of the fabric clock. At the start of each read the flash drives a fixed 8-bit learning pattern during its dummy beats. The block compares every tap against that pattern on all lanes. It keeps the taps that match in full, picks the middle of the longest group of neighbouring matching taps, and captures every later data beat of the same read through that single tap.

Training runs again on every read, so the tap follows slow changes in board and device skew. If no tap matches, the block keeps the tap it used before and raises a failure flag. It still passes the data on, with each beat marked as suspect.

Top module: `tpa_capture_aligner`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `cap_vld`, `cap_err` and `train_fail` are 0 and `sel_tap` equals NTAPS/2 (4 by default).
- R2: A `rd_start` pulse opens training. The next PAT_LEN cycles with `beat_vld` high are training beats, and beat k carries bit PAT_LEN-1-k of PATTERN (default 8'h34, most significant bit first) on every lane. Lane l of tap t sits on `tap_bus[t*LANES + l]`.
- R3: A tap counts as valid only if each of its lanes equals the expected bit on every training beat. A single wrong lane on a single beat makes the tap invalid.
- R4: The chosen tap is s + (n-1)/2, rounded down, where s is the lowest tap and n the length of the longest run of adjacent valid taps. When two runs have the same length, the run with the lower index wins.
- R5: `sel_tap` and `train_fail` change only at the clock edge that takes the last training beat. The new values are visible from the next cycle and hold until the next read completes training.
- R6: Each `beat_vld` cycle after training, until `rd_done` or the next `rd_start`, is a data beat. One cycle later it appears as `cap_vld`=1 with `cap_data` equal to the lanes of tap `sel_tap`.
- R7: If no tap is valid, `train_fail` goes to 1 and `sel_tap` stays unchanged. Data beats of that read are still output, with `cap_err`=1.
- R8: A read whose training finds a valid tap clears `train_fail`, and its data beats carry `cap_err`=0. `cap_err` is never 1 without `cap_vld`.
- R9: Every `rd_start` begins a fresh training, even in the middle of a read's data beats. After `rd_done`, and during training, beats with `beat_vld` produce no `cap_vld`.
- R10: Cycles with `beat_vld` low do not advance training and produce no output, whatever `tap_bus` carries in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Pulse: a read begins, training beats follow |
| rd_done | input | 1 | Pulse: the current read has ended |
| beat_vld | input | 1 | `tap_bus` holds a beat this cycle |
| tap_bus | input | NTAPS*LANES | All lanes at all delay taps, tap-major |
| cap_data | output | LANES | Captured beat from the selected tap |
| cap_vld | output | 1 | `cap_data` holds a data beat |
| cap_err | output | 1 | Beat was captured after failed training |
| sel_tap | output | $clog2(NTAPS) | Tap in use for data capture |
| train_fail | output | 1 | Last training found no valid tap |

## Verification
The assertions assume that `rd_start` and `rd_done` are single-cycle pulses and that `beat_vld` is never high in the same cycle as either of them. Under that assumption the last training beat and the data beats never fall in the same cycle. The bench raises each control pulse for exactly one negative-edge-to-negative-edge slot, with `beat_vld` held low in that slot, and changes every input only on the falling clock edge. It drives random values on `tap_bus` in cycles without a beat, so that those cycles are exercised without breaking the assumed protocol.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRAIN = 2'd1,
    PH_DATA  = 2'd2
  } tpa_phase_e;
endpackage

// File: rtl/tpa_beat_ctrl.sv
module tpa_beat_ctrl #(
  parameter int PAT_LEN = 8,
  parameter logic [PAT_LEN-1:0] PATTERN = 'h34
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_start,
  input  logic rd_done,
  input  logic beat_vld,
  output logic clr_match,
  output logic train_step,
  output logic last_train,
  output logic data_beat,
  output logic exp_bit
);
  import tpa_pkg::*;

  localparam int CNT_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAT_LEN - 1);

  tpa_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAT_LEN-1:0] pat_q;
  logic              quiet;

  // control pulses take precedence over a beat in the same cycle
  assign quiet      = !rd_start && !rd_done;
  assign clr_match  = rd_start;
  assign train_step = (phase_q == PH_TRAIN) && beat_vld && quiet;
  assign last_train = train_step && (cnt_q == LAST_IDX);
  assign data_beat  = (phase_q == PH_DATA) && beat_vld && quiet;
  assign exp_bit    = pat_q[PAT_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pat_q   <= PATTERN;
    end else if (rd_start) begin
      phase_q <= PH_TRAIN;
      cnt_q   <= '0;
      pat_q   <= PATTERN;
    end else if (rd_done) begin
      phase_q <= PH_IDLE;
    end else if (train_step) begin
      cnt_q <= cnt_q + 1'b1;
      pat_q <= {pat_q[PAT_LEN-2:0], 1'b0};
      if (last_train) phase_q <= PH_DATA;
    end
  end
endmodule

// File: rtl/tpa_lane_match.sv
module tpa_lane_match #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             exp_bit,
  input  logic [LANES-1:0] lines,
  output logic             hit
);
  logic match_q;
  logic agree;

  assign agree = (lines == {LANES{exp_bit}});
  // includes the beat being taken now, so it is final on the last beat
  assign hit = match_q && agree;

  always_ff @(posedge clk) begin
    if (rst || clr) match_q <= 1'b1;
    else if (step)  match_q <= hit;
  end
endmodule

// File: rtl/tpa_run_pick.sv
module tpa_run_pick #(
  parameter int NTAPS = 8,
  parameter int TAP_W = 3
) (
  input  logic [NTAPS-1:0] valid_taps,
  output logic [TAP_W-1:0] pick,
  output logic             none
);
  int cur_len, cur_start, best_len, best_start;

  always_comb begin
    cur_len    = 0;
    cur_start  = 0;
    best_len   = 0;
    best_start = 0;
    for (int i = 0; i < NTAPS; i++) begin
      if (valid_taps[i]) begin
        if (cur_len == 0) cur_start = i;
        cur_len = cur_len + 1;
        if (cur_len > best_len) begin
          best_len   = cur_len;
          best_start = cur_start;
        end
      end else begin
        cur_len = 0;
      end
    end
    none = (best_len == 0);
    pick = none ? '0 : TAP_W'(best_start + (best_len - 1) / 2);
  end
endmodule

// File: rtl/tpa_capture_aligner.sv
module tpa_capture_aligner #(
  parameter int NTAPS   = 8,
  parameter int LANES   = 4,
  parameter int PAT_LEN = 8,
  parameter logic [PAT_LEN-1:0] PATTERN = 'h34,
  localparam int TAP_W  = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_start,
  input  logic                   rd_done,
  input  logic                   beat_vld,
  input  logic [NTAPS*LANES-1:0] tap_bus,
  output logic [LANES-1:0]       cap_data,
  output logic                   cap_vld,
  output logic                   cap_err,
  output logic [TAP_W-1:0]       sel_tap,
  output logic                   train_fail
);
  localparam logic [TAP_W-1:0] RST_TAP = TAP_W'(NTAPS / 2);

  logic             clr_match, train_step, last_train, data_beat, exp_bit;
  logic [NTAPS-1:0] tap_hit;
  logic [TAP_W-1:0] pick;
  logic             no_valid;
  logic [LANES-1:0] tap_lines [NTAPS];

  tpa_beat_ctrl #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_ctrl (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_done(rd_done),
    .beat_vld(beat_vld), .clr_match(clr_match), .train_step(train_step),
    .last_train(last_train), .data_beat(data_beat), .exp_bit(exp_bit)
  );

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    assign tap_lines[t] = tap_bus[t*LANES +: LANES];
    tpa_lane_match #(.LANES(LANES)) u_match (
      .clk(clk), .rst(rst), .clr(clr_match), .step(train_step),
      .exp_bit(exp_bit), .lines(tap_lines[t]), .hit(tap_hit[t])
    );
  end

  tpa_run_pick #(.NTAPS(NTAPS), .TAP_W(TAP_W)) u_pick (
    .valid_taps(tap_hit), .pick(pick), .none(no_valid)
  );

  // tap decision, taken on the edge of the final training beat
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_tap    <= RST_TAP;
      train_fail <= 1'b0;
    end else if (last_train) begin
      train_fail <= no_valid;
      if (!no_valid) sel_tap <= pick;
    end
  end

  // data capture through the held tap
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld  <= 1'b0;
      cap_err  <= 1'b0;
      cap_data <= '0;
    end else begin
      cap_vld <= data_beat;
      cap_err <= data_beat && train_fail;
      if (data_beat) cap_data <= tap_lines[sel_tap];
    end
  end
endmodule

// File: rtl/tpa_capture_aligner_chk.sv
module tpa_capture_aligner_chk #(
  parameter int TAP_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             beat_vld,
  input logic             cap_vld,
  input logic             cap_err,
  input logic [TAP_W-1:0] sel_tap,
  input logic             train_fail,
  input logic             last_train,
  input logic             no_valid
);
  a_r6_vld_after_beat: assert property (@(posedge clk) disable iff (rst)
    cap_vld |-> $past(beat_vld));

  a_r5_tap_held: assert property (@(posedge clk) disable iff (rst)
    !last_train |=> $stable(sel_tap));

  a_r5_fail_held: assert property (@(posedge clk) disable iff (rst)
    !last_train |=> $stable(train_fail));

  a_r7_fail_keeps_tap: assert property (@(posedge clk) disable iff (rst)
    (last_train && no_valid) |=> ($stable(sel_tap) && train_fail));

  a_r8_pass_clears: assert property (@(posedge clk) disable iff (rst)
    (last_train && !no_valid) |=> !train_fail);

  a_r8_err_needs_vld: assert property (@(posedge clk) disable iff (rst)
    cap_err |-> cap_vld);

  a_r7_err_marks_fail: assert property (@(posedge clk) disable iff (rst)
    cap_vld |-> (cap_err == train_fail));
endmodule

bind tpa_capture_aligner tpa_capture_aligner_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst(rst), .beat_vld(beat_vld), .cap_vld(cap_vld),
  .cap_err(cap_err), .sel_tap(sel_tap), .train_fail(train_fail),
  .last_train(last_train), .no_valid(no_valid)
);

// File: tb/tpa_capture_aligner_test.sv
module tpa_capture_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int LN = 4;
  localparam logic [7:0] PAT = 8'h34;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_start = 1'b0, rd_done = 1'b0, beat_vld = 1'b0;
  logic [NT*LN-1:0] tap_bus = '0;
  logic [LN-1:0] cap_data;
  logic cap_vld, cap_err, train_fail;
  logic [2:0] sel_tap;

  int checks = 0;
  int errors = 0;
  int exp_sel = NT / 2;
  logic [4:0] sb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tpa_capture_aligner uut (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_done(rd_done),
    .beat_vld(beat_vld), .tap_bus(tap_bus), .cap_data(cap_data),
    .cap_vld(cap_vld), .cap_err(cap_err), .sel_tap(sel_tap),
    .train_fail(train_fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // independent model of the longest-run middle rule (R4)
  function automatic int model_pick(input logic [NT-1:0] v, output bit none);
    int cl = 0, cs = 0, bl = 0, bs = 0;
    for (int i = 0; i < NT; i++) begin
      if (v[i]) begin
        if (cl == 0) cs = i;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    none = (bl == 0);
    return bs + (bl - 1) / 2;
  endfunction

  function automatic logic [NT*LN-1:0] spread(input logic [LN-1:0] lanes,
      input logic [NT-1:0] bad_taps, input logic [LN-1:0] bad_lanes, input bit corrupt);
    logic [NT*LN-1:0] w;
    for (int t = 0; t < NT; t++)
      w[t*LN +: LN] = lanes ^ ((corrupt && bad_taps[t]) ? bad_lanes : '0);
    return w;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && cap_vld) begin
      if (sb.size() == 0) chk(0, "R9", 1, 0);
      else begin
        logic [4:0] e;
        e = sb.pop_front();
        chk({cap_err, cap_data} == e, "R6/R7", {cap_err, cap_data}, e);
      end
    end
  end

  task automatic gap_cycles(input int n);
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      beat_vld = 1'b0;
      tap_bus  = {$urandom, $urandom};  // R10: ignored garbage
    end
  endtask

  task automatic run_txn(input logic [NT-1:0] bad_taps, input logic [LN-1:0] bad_lanes,
      input int bad_beat, input int ndata, input int gap, input bit finish,
      input logic [3:0] seed);
    logic [NT-1:0] v;
    bit none;
    int p;
    for (int t = 0; t < NT; t++)
      v[t] = !(bad_taps[t] && bad_lanes != 0 && (bad_beat < 0 || bad_beat < 8));
    p = model_pick(v, none);
    if (!none) exp_sel = p;
    @(negedge clk);
    beat_vld = 1'b0; rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      beat_vld = 1'b1;
      tap_bus  = spread({LN{PAT[7-k]}}, bad_taps, bad_lanes, bad_beat < 0 || bad_beat == k);
      gap_cycles(gap);
    end
    @(negedge clk);
    beat_vld = 1'b0;
    chk(sel_tap == 3'(exp_sel), "R4/R5", sel_tap, exp_sel);
    chk(train_fail == none, "R7/R8", train_fail, none);
    for (int j = 0; j < ndata; j++) begin
      logic [LN-1:0] d;
      logic [NT*LN-1:0] w;
      d = seed + 4'(j * 5);
      w = spread(d, bad_taps, bad_lanes, bad_beat < 0 || bad_beat == 8 + j);
      if (j > 0 || gap > 0) @(negedge clk);
      beat_vld = 1'b1;
      tap_bus  = w;
      sb.push_back({none, w[exp_sel*LN +: LN]});
      gap_cycles(gap);
    end
    @(negedge clk);
    beat_vld = 1'b0;
    if (finish) begin
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cap_vld && !cap_err && !train_fail && sel_tap == 3'd4, "R1",
        {cap_vld, cap_err, train_fail, sel_tap}, 4);
    rst = 1'b0;
    @(negedge clk);
    chk(!cap_vld && !cap_err && !train_fail && sel_tap == 3'd4, "R1",
        {cap_vld, cap_err, train_fail, sel_tap}, 4);
    // R2/R4: all taps match -> middle of 0..7 is 3
    run_txn(8'h00, 4'h0, -1, 4, 0, 1, 4'h1);
    // R4: valid 2..6 -> 4
    run_txn(8'b1000_0011, 4'hF, -1, 3, 0, 1, 4'h2);
    // R4: runs {0,1} and {4..6} -> 5
    run_txn(8'b1000_1100, 4'h2, -1, 3, 0, 1, 4'h3);
    // R4: tie {1,2} vs {5,6} -> lower run, tap 1
    run_txn(8'b1001_1001, 4'h1, -1, 2, 0, 1, 4'h7);
    // R3: tap 6 wrong only on lane 3 of the last training beat -> tap 2
    run_txn(8'b0100_0000, 4'h8, 7, 2, 0, 1, 4'h9);
    // R3: taps 0..4 wrong only on lane 1 of the first beat -> tap 6
    run_txn(8'b0001_1111, 4'h2, 0, 2, 0, 1, 4'hA);
    // R7: no valid tap -> tap 6 kept, data marked
    run_txn(8'hFF, 4'h5, -1, 3, 0, 1, 4'hC);
    // R8/R10: valid again, with idle garbage cycles between beats
    run_txn(8'h00, 4'h0, -1, 3, 2, 1, 4'h4);
    // R6: first data beat corrupted on tap 3 shows capture comes from tap 3
    run_txn(8'b0000_1000, 4'hF, 8, 3, 0, 1, 4'h6);
    // R9: restart in the middle of a read's data beats -> valid 0..4, tap 2
    run_txn(8'h00, 4'h0, -1, 2, 0, 0, 4'hB);
    run_txn(8'b1110_0000, 4'h4, -1, 2, 0, 1, 4'hD);
    // R9: beats after rd_done produce nothing
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      beat_vld = 1'b1;
      tap_bus  = {$urandom, $urandom};
    end
    @(negedge clk);
    beat_vld = 1'b0;
    chk(!cap_vld, "R9", cap_vld, 0);
    @(negedge clk);
    chk(!cap_vld && sel_tap == 3'd2, "R9", {cap_vld, sel_tap}, 2);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R6", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule